// File: doc/BRIEF.md
# Serial LUT Path-Select Loader

This controller reprograms a chain of reconfigurable 5-input lookup tables through their shared serial configuration port. Each table in the chain becomes a two-input NAND. One operand is always address input 4. The other comes from one of two routing paths, either address input 0 or address input 1. The wiring between elements is fixed: every element's output drives two inputs of its successor. Changing which of those two inputs the NAND reads therefore picks the routing path without touching the routing.

A host presents one select bit per element and pulses `go`. The loader computes each element's 32-entry truth table on the fly and streams the tables into the chain, one bit per cycle, with a clock-enable strobe. It holds the ring's oscillator enable low for the whole transfer and pulses `done` when the last bit has gone out. A three-element chain is the smallest ring and is the default.

Top module: `lut_path_loader`

## Requirements
- R1: After reset, `busy`, `done`, `err` and `cfgEn` are 0 and `oscEn` is 1.
- R2: A `go` seen at a clock edge while idle starts a load, and `busy` is 1 from the following cycle. `selWord` is captured at that same edge, and later changes to it do not alter the load in progress.
- R3: For element e with select bit s = `selWord[e]`, truth-table entry a (address a, 0..31) is 0 only when address bit 4 is 1 and address bit s is 1. Here s=0 means address bit 0 and s=1 means address bit 1. Every other entry is 1.
- R4: Tables are sent starting with element NUM_ELEM-1 and ending with element 0, and each table is sent from entry 31 down to entry 0, one entry per cycle in which `cfgEn` is 1.
- R5: During a load, `cfgEn` is 1 for exactly 32*NUM_ELEM consecutive cycles, which are exactly the cycles in which `busy` is 1. `cfgData` is 0 whenever `cfgEn` is 0.
- R6: `done` is 1 for exactly one cycle, namely the cycle right after the final shift, and `busy` is 0 in that cycle.
- R7: `oscEn` is 0 in every cycle in which `busy` is 1, and 1 otherwise.
- R8: A `go` that arrives while `busy` is 1 leaves the stream unchanged and sets `err`. Once set, `err` stays 1 until reset.
- R9: Each LUT shifts its table in from its low end and passes its bit 31 on to the next LUT. After a complete load through a chain built this way, LUT e holds exactly the R3 table for `selWord[e]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| selWord | input | NUM_ELEM | Path select per element (0: input 0, 1: input 1) |
| go | input | 1 | Start a load |
| cfgData | output | 1 | Serial configuration bit into the first LUT |
| cfgEn | output | 1 | Shift enable for the LUT chain |
| oscEn | output | 1 | Ring oscillator enable, low while loading |
| busy | output | 1 | Load in progress |
| done | output | 1 | One-cycle pulse after the last shift |
| err | output | 1 | Sticky flag: `go` received while busy |

## Verification
Suppose the element or entry position drifts. The error then appears on `cfgData` in the very cycle it occurs, as a wrong bit in the stream. It also survives in the chain as a misplaced or mixed table once the load is over. Suppose instead the length of the transfer is miscounted. `done` then fires early or late relative to the 32*NUM_ELEM enables, and the tables land shifted by whole or partial positions. A spurious or missing error capture shows on `err` one cycle after the offending `go` and persists.

// File: rtl/lut_path_loader_pkg.sv
package lut_path_loader_pkg;

  localparam int LUT_INPUTS = 5;
  localparam int TABLE_BITS = 1 << LUT_INPUTS;

  // Address input shared by both NAND variants, and the two path inputs.
  localparam int SHARED_IN = 4;
  localparam int PATH0_IN  = 0;
  localparam int PATH1_IN  = 1;

  typedef struct packed {
    logic load;   // capture selection, rewind position
    logic shift;  // emit one configuration bit
  } loadStrobe_t;

  // One truth-table entry of the selected NAND variant.
  function automatic logic nandTableBit(input logic pathSel,
                                        input logic [LUT_INPUTS-1:0] addr);
    logic pathIn;
    pathIn = pathSel ? addr[PATH1_IN] : addr[PATH0_IN];
    return ~(addr[SHARED_IN] & pathIn);
  endfunction

endpackage

// File: rtl/lut_path_loader_ctrl.sv
module lut_path_loader_ctrl
  import lut_path_loader_pkg::*;
#(
  parameter int NUM_ELEM = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        go,
  input  logic        lastBit,
  output loadStrobe_t strobes,
  output logic        busy,
  output logic        done,
  output logic        err
);

  localparam int TOTAL_SHIFTS = TABLE_BITS * NUM_ELEM;
  localparam int CNT_W        = $clog2(TOTAL_SHIFTS + 1);

  typedef enum logic {ST_IDLE, ST_SHIFT} ctrlState_t;

  ctrlState_t state;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      done  <= 1'b0;
      err   <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: if (go) state <= ST_SHIFT;
        ST_SHIFT: begin
          if (lastBit) begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end
          if (go) err <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy          = (state == ST_SHIFT);
  assign strobes.load  = go && (state == ST_IDLE);
  assign strobes.shift = (state == ST_SHIFT);

  // Window counter used only by the length checks below.
  logic [CNT_W-1:0] shiftCnt;
  always_ff @(posedge clk) begin
    if (!rstN)             shiftCnt <= '0;
    else if (strobes.load) shiftCnt <= '0;
    else if (busy)         shiftCnt <= shiftCnt + 1'b1;
  end

  p_len_exact_r5: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (shiftCnt == CNT_W'(TOTAL_SHIFTS)));
  p_len_bound_r5: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (shiftCnt < CNT_W'(TOTAL_SHIFTS)));
  p_done_after_r6: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && $past(busy)));
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  p_err_set_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busy && go) |=> err);
  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    err |=> err);

endmodule

// File: rtl/lut_path_loader_dp.sv
module lut_path_loader_dp
  import lut_path_loader_pkg::*;
#(
  parameter int NUM_ELEM = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  loadStrobe_t         strobes,
  input  logic [NUM_ELEM-1:0] selWord,
  output logic                cfgData,
  output logic                cfgEn,
  output logic                lastBit
);

  localparam int ELEM_W = (NUM_ELEM > 1) ? $clog2(NUM_ELEM) : 1;
  localparam logic [ELEM_W-1:0]     LAST_ELEM = ELEM_W'(NUM_ELEM - 1);
  localparam logic [LUT_INPUTS-1:0] TOP_BIT   = LUT_INPUTS'(TABLE_BITS - 1);

  logic [NUM_ELEM-1:0]   selReg;
  logic [LUT_INPUTS-1:0] bitIdx;
  logic [ELEM_W-1:0]     elemIdx;
  logic                  activeSel;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selReg  <= '0;
      bitIdx  <= TOP_BIT;
      elemIdx <= LAST_ELEM;
    end else if (strobes.load) begin
      selReg  <= selWord;
      bitIdx  <= TOP_BIT;
      elemIdx <= LAST_ELEM;
    end else if (strobes.shift) begin
      bitIdx <= bitIdx - 1'b1;
      if (bitIdx == '0) elemIdx <= elemIdx - 1'b1;
    end
  end

  // Pick the select bit of the element currently on the wire.
  generate
    if (NUM_ELEM == 1) begin : g_single
      assign activeSel = selReg[0];
    end else begin : g_multi
      always_comb begin
        activeSel = 1'b0;
        for (int e = 0; e < NUM_ELEM; e++)
          if (elemIdx == ELEM_W'(e)) activeSel = selReg[e];
      end
    end
  endgenerate

  assign cfgEn   = strobes.shift;
  assign cfgData = strobes.shift & nandTableBit(activeSel, bitIdx);
  assign lastBit = (bitIdx == '0) && (elemIdx == '0);

  p_elem_range_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.shift |-> (elemIdx <= LAST_ELEM));
  p_bit_order_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.shift && $past(strobes.shift) && bitIdx != TOP_BIT)
      |-> (bitIdx == LUT_INPUTS'($past(bitIdx) - 1'b1)));
  p_start_pos_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.load |=> (bitIdx == TOP_BIT && elemIdx == LAST_ELEM));
  p_sel_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.shift && !$past(strobes.load)) |-> $stable(selReg));

endmodule

// File: rtl/lut_path_loader.sv
module lut_path_loader
  import lut_path_loader_pkg::*;
#(
  parameter int NUM_ELEM = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_ELEM-1:0] selWord,
  input  logic                go,
  output logic                cfgData,
  output logic                cfgEn,
  output logic                oscEn,
  output logic                busy,
  output logic                done,
  output logic                err
);

  loadStrobe_t strobes;
  logic        lastBit;

  lut_path_loader_ctrl #(.NUM_ELEM(NUM_ELEM)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .go      (go),
    .lastBit (lastBit),
    .strobes (strobes),
    .busy    (busy),
    .done    (done),
    .err     (err)
  );

  lut_path_loader_dp #(.NUM_ELEM(NUM_ELEM)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .selWord (selWord),
    .cfgData (cfgData),
    .cfgEn   (cfgEn),
    .lastBit (lastBit)
  );

  // Ring stays stopped while its tables are being rewritten.
  assign oscEn = ~busy;

  p_osc_stopped_r7: assert property (@(posedge clk) disable iff (!rstN)
    cfgEn |-> !oscEn);

endmodule

// File: tb/lut_path_loader_tb.sv
module lut_path_loader_tb;

  localparam int N  = 3;
  localparam int TB = 32;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [N-1:0] selWord = '0;
  logic         go = 1'b0;
  logic         cfgData, cfgEn, oscEn, busy, done, err;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  lut_path_loader #(.NUM_ELEM(N)) u_dut (
    .clk(clk), .rstN(rstN), .selWord(selWord), .go(go),
    .cfgData(cfgData), .cfgEn(cfgEn), .oscEn(oscEn),
    .busy(busy), .done(done), .err(err)
  );

  // Chain of LUT models: shift in at bit 0, pass bit 31 to the next element.
  logic [TB-1:0] chainModel [N];
  always_ff @(posedge clk) begin
    if (cfgEn) begin
      chainModel[0] <= {chainModel[0][TB-2:0], cfgData};
      for (int e = 1; e < N; e++)
        chainModel[e] <= {chainModel[e][TB-2:0], chainModel[e-1][TB-1]};
    end
  end

  // R3 table entry, computed arithmetically.
  function automatic int expBit(input int s, input int a);
    int pathBit;
    pathBit = (s != 0) ? (a / 2) % 2 : a % 2;
    return ((a >= 16) && (pathBit == 1)) ? 0 : 1;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic runLoad(input logic [N-1:0] sel, input int injectAt);
    int mism [N];
    int badCfg, badOsc, badBusy;
    badCfg = 0; badOsc = 0; badBusy = 0;
    for (int e = 0; e < N; e++) mism[e] = 0;
    @(negedge clk); selWord = sel; go = 1'b1;
    @(negedge clk); go = 1'b0; selWord = ~sel;  // R2: late change ignored
    for (int k = 0; k < N * TB; k++) begin
      int elem, bitI;
      elem = N - 1 - k / TB;
      bitI = TB - 1 - k % TB;
      if (cfgEn !== 1'b1) badCfg++;
      if (oscEn !== 1'b0) badOsc++;
      if (busy !== 1'b1) badBusy++;
      if (int'(cfgData) != expBit(int'(sel[elem]), bitI)) mism[elem]++;
      if (k == injectAt) begin go = 1'b1; selWord = sel ^ 3'b011; end
      if (k == injectAt + 1) go = 1'b0;
      @(negedge clk);
    end
    for (int e = 0; e < N; e++)
      check(mism[e] == 0, "R3/R4", $sformatf("stream mismatches elem %0d sel %0d", e, sel),
            mism[e], 0);
    check(badCfg == 0, "R5", "cycles without cfgEn during load", badCfg, 0);
    check(badBusy == 0, "R2", "cycles without busy during load", badBusy, 0);
    check(badOsc == 0, "R7", "cycles with oscEn high during load", badOsc, 0);
    check(done === 1'b1 && busy === 1'b0, "R6", "done/busy after last shift",
          {done, busy}, 2);
    check(cfgEn === 1'b0 && cfgData === 1'b0, "R5", "cfgEn/cfgData after load",
          {cfgEn, cfgData}, 0);
    check(oscEn === 1'b1, "R7", "oscEn after load", oscEn, 1);
    @(negedge clk);
    check(done === 1'b0, "R6", "done second cycle", done, 0);
    for (int e = 0; e < N; e++) begin
      int bad;
      bad = 0;
      for (int a = 0; a < TB; a++)
        if (int'(chainModel[e][a]) != expBit(int'(sel[e]), a)) bad++;
      check(bad == 0, "R9", $sformatf("chain table entries wrong elem %0d", e), bad, 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(busy === 1'b0 && done === 1'b0 && err === 1'b0 && cfgEn === 1'b0,
          "R1", "busy/done/err/cfgEn in reset", {busy, done, err, cfgEn}, 0);
    check(oscEn === 1'b1, "R1", "oscEn in reset", oscEn, 1);
    rstN = 1'b1;
    for (int s = 0; s < (1 << N); s++) runLoad(N'(s), -1);
    check(err === 1'b0, "R8", "err after clean loads", err, 0);
    runLoad(3'b101, 40);  // R8: go while busy
    check(err === 1'b1, "R8", "err after go while busy", err, 1);
    runLoad(3'b010, -1);
    check(err === 1'b1, "R8", "err sticky over next load", err, 1);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule